// File: doc/BRIEF.md
# Tristate GPIO Controller with Source Selection

This block is a 32-pin general-purpose I/O peripheral on a simple word-wide register bus. Software writes a per-pin output value, a per-pin drive enable and a per-pin open-drain mode. It also writes 2-bit routing fields that pick, for each pin, where its output value and its drive enable come from: the GPIO registers, or one of three alternate-function sources that arrive on input ports. A read-only input register returns the pin levels after a two-flop synchroniser.

Pins are numbered from the most significant end. Pin n occupies bit 31-n of every one-bit-per-pin register and of the pin vectors. The routing fields are two bits wide. Pins 0 to 15 keep their fields in a low register and pins 16 to 31 keep theirs in a high register. Three receive-routing words and six input-routing words are plain storage with no effect on the pins.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every writable register reads zero, and every pin has pin_oe low.
- R2: Pin n maps to bit 31-n of every one-bit-per-pin register (value 0x00, drive 0x04, open-drain 0x18, input 0x1C) and of pin_i, pin_o, pin_oe and the alt ports.
- R3: With both routing fields 00 and open-drain off, pin_oe of a pin equals its drive-enable bit (1 drives, 0 floats) and pin_o equals its output-value bit.
- R4: Output-routing fields live at 0x08 for pins 0-15 and at 0x0C for pins 16-31. Drive-routing fields live at 0x10 for pins 0-15 and at 0x14 for pins 16-31. Pin n's field occupies bits [31-2*(n%16) : 30-2*(n%16)].
- R5: An output-routing field of 01, 10 or 11 takes the pin's value from alt_out1, alt_out2 or alt_out3 respectively.
- R6: A drive-routing field of 01, 10 or 11 takes the pin's enable from alt_oe1, alt_oe2 or alt_oe3 respectively.
- R7: With the open-drain bit set, pin_o is 0 and pin_oe is the routed enable AND the inverse of the routed value.
- R8: The input register at 0x1C returns pin_i through two synchronising flops. A change of pin_i first shows in a read whose address is presented two cycles after the change. Writes to 0x1C are ignored.
- R9: Reads have one cycle of latency: bus_rdata changes at the clock edge that samples the address and holds until the next edge.
- R10: The writable words read back what was last written: 0x00-0x18, receive routing 0x20-0x28 and input routing 0x30-0x44. A register changes only when it is written.
- R11: The reserved word 0x2C, any offset above 0x44 and any address with nonzero low two bits read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| alt_out1 | input | 32 | Alternate source 1 output values |
| alt_out2 | input | 32 | Alternate source 2 output values |
| alt_out3 | input | 32 | Alternate source 3 output values |
| alt_oe1 | input | 32 | Alternate source 1 drive enables |
| alt_oe2 | input | 32 | Alternate source 2 drive enables |
| alt_oe3 | input | 32 | Alternate source 3 drive enables |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin drive enables |

## Verification
The bench goes after the bit-ordering corners. Pin 0 sits at bit 31. Pin 16 is the first field of the high routing word, so a design that indexes the fields LSB-first or splits the halves at the wrong pin routes the wrong alternate source. Open-drain with a routed value of 1 must release the pin: a design that merely forces pin_o to 0 would drive low when it should float. The input read is timed cycle by cycle, so a missing or extra synchroniser stage shows as a read one cycle early or late. Writes to the input, reserved and unmapped words are followed by reads that would expose any storage behind them.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
    localparam int NPIN   = 32;
    localparam int DW     = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int SEL_W  = 2;
    localparam int NALT   = (1 << SEL_W) - 1;
    localparam int NRX    = 3;
    localparam int NISEL  = 6;
    localparam int HALF   = NPIN / 2;

    // word index; order fixed by the bus map
    typedef enum logic [IDX_W-1:0] {
        IDX_OUT     = 6'd0,
        IDX_DRV     = 6'd1,
        IDX_OSEL_LO = 6'd2,
        IDX_OSEL_HI = 6'd3,
        IDX_DSEL_LO = 6'd4,
        IDX_DSEL_HI = 6'd5,
        IDX_OD      = 6'd6,
        IDX_IN      = 6'd7,
        IDX_RX0     = 6'd8,
        IDX_RX1     = 6'd9,
        IDX_RX2     = 6'd10,
        IDX_RSV     = 6'd11,
        IDX_IS0     = 6'd12,
        IDX_IS1     = 6'd13,
        IDX_IS2     = 6'd14,
        IDX_IS3     = 6'd15,
        IDX_IS4     = 6'd16,
        IDX_IS5     = 6'd17
    } reg_idx_e;

    localparam logic [IDX_W-1:0] LAST_IDX = 6'd17;

    typedef struct packed {
        logic [DW-1:0]            out_val;
        logic [DW-1:0]            drv_en;
        logic [DW-1:0]            osel_lo;
        logic [DW-1:0]            osel_hi;
        logic [DW-1:0]            dsel_lo;
        logic [DW-1:0]            dsel_hi;
        logic [DW-1:0]            od_en;
        logic [NRX-1:0][DW-1:0]   rx_sel;
        logic [NISEL-1:0][DW-1:0] in_sel;
    } regs_t;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     in_level,
    output logic [DW-1:0]     rdata,
    output regs_t             regs
);
    typedef struct packed {
        regs_t         regs;
        logic [DW-1:0] rdata;
    } state_t;

    state_t   st_d, st_q;
    reg_idx_e idx;
    logic     aligned;
    logic     mapped;

    assign idx     = reg_idx_e'(addr[ADDR_W-1:2]);
    assign aligned = (addr[1:0] == 2'b00);
    assign mapped  = aligned && (addr[ADDR_W-1:2] <= LAST_IDX);

    always_comb begin
        st_d = st_q;
        if (we && mapped) begin
            case (idx)
                IDX_OUT:     st_d.regs.out_val   = wdata;
                IDX_DRV:     st_d.regs.drv_en    = wdata;
                IDX_OSEL_LO: st_d.regs.osel_lo   = wdata;
                IDX_OSEL_HI: st_d.regs.osel_hi   = wdata;
                IDX_DSEL_LO: st_d.regs.dsel_lo   = wdata;
                IDX_DSEL_HI: st_d.regs.dsel_hi   = wdata;
                IDX_OD:      st_d.regs.od_en     = wdata;
                IDX_RX0:     st_d.regs.rx_sel[0] = wdata;
                IDX_RX1:     st_d.regs.rx_sel[1] = wdata;
                IDX_RX2:     st_d.regs.rx_sel[2] = wdata;
                IDX_IS0:     st_d.regs.in_sel[0] = wdata;
                IDX_IS1:     st_d.regs.in_sel[1] = wdata;
                IDX_IS2:     st_d.regs.in_sel[2] = wdata;
                IDX_IS3:     st_d.regs.in_sel[3] = wdata;
                IDX_IS4:     st_d.regs.in_sel[4] = wdata;
                IDX_IS5:     st_d.regs.in_sel[5] = wdata;
                default:     ;
            endcase
        end

        st_d.rdata = '0;
        if (mapped) begin
            case (idx)
                IDX_OUT:     st_d.rdata = st_q.regs.out_val;
                IDX_DRV:     st_d.rdata = st_q.regs.drv_en;
                IDX_OSEL_LO: st_d.rdata = st_q.regs.osel_lo;
                IDX_OSEL_HI: st_d.rdata = st_q.regs.osel_hi;
                IDX_DSEL_LO: st_d.rdata = st_q.regs.dsel_lo;
                IDX_DSEL_HI: st_d.rdata = st_q.regs.dsel_hi;
                IDX_OD:      st_d.rdata = st_q.regs.od_en;
                IDX_IN:      st_d.rdata = in_level;
                IDX_RX0:     st_d.rdata = st_q.regs.rx_sel[0];
                IDX_RX1:     st_d.rdata = st_q.regs.rx_sel[1];
                IDX_RX2:     st_d.rdata = st_q.regs.rx_sel[2];
                IDX_IS0:     st_d.rdata = st_q.regs.in_sel[0];
                IDX_IS1:     st_d.rdata = st_q.regs.in_sel[1];
                IDX_IS2:     st_d.rdata = st_q.regs.in_sel[2];
                IDX_IS3:     st_d.rdata = st_q.regs.in_sel[3];
                IDX_IS4:     st_d.rdata = st_q.regs.in_sel[4];
                IDX_IS5:     st_d.rdata = st_q.regs.in_sel[5];
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign regs  = st_q.regs;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mapped || idx == IDX_RSV) |=> (rdata == '0)); // R11

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || !mapped) |=> $stable(regs)); // R10

    AST_INPUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mapped && idx == IDX_IN) |=> (rdata == $past(in_level))); // R8
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = raw;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign synced = sy_q.s2;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ctrl_pkg::*;
(
    input  regs_t                     regs,
    input  logic [NALT-1:0][NPIN-1:0] alt_out,
    input  logic [NALT-1:0][NPIN-1:0] alt_oe,
    output logic [NPIN-1:0]           pin_o,
    output logic [NPIN-1:0]           pin_oe
);
    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        localparam int B = NPIN - 1 - n;
        localparam int F = DW - 1 - SEL_W * (n % HALF);

        logic [SEL_W-1:0] osel;
        logic [SEL_W-1:0] dsel;
        logic             val;
        logic             en;

        if (n < HALF) begin : g_lo
            assign osel = regs.osel_lo[F -: SEL_W];
            assign dsel = regs.dsel_lo[F -: SEL_W];
        end else begin : g_hi
            assign osel = regs.osel_hi[F -: SEL_W];
            assign dsel = regs.dsel_hi[F -: SEL_W];
        end

        always_comb begin
            case (osel)
                2'd1:    val = alt_out[0][B];
                2'd2:    val = alt_out[1][B];
                2'd3:    val = alt_out[2][B];
                default: val = regs.out_val[B];
            endcase
            case (dsel)
                2'd1:    en = alt_oe[0][B];
                2'd2:    en = alt_oe[1][B];
                2'd3:    en = alt_oe[2][B];
                default: en = regs.drv_en[B];
            endcase
        end

        assign pin_o[B]  = regs.od_en[B] ? 1'b0 : val;
        assign pin_oe[B] = regs.od_en[B] ? (en & ~val) : en;
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPIN-1:0]   alt_out1,
    input  logic [NPIN-1:0]   alt_out2,
    input  logic [NPIN-1:0]   alt_out3,
    input  logic [NPIN-1:0]   alt_oe1,
    input  logic [NPIN-1:0]   alt_oe2,
    input  logic [NPIN-1:0]   alt_oe3,
    input  logic [NPIN-1:0]   pin_i,
    output logic [NPIN-1:0]   pin_o,
    output logic [NPIN-1:0]   pin_oe
);
    regs_t                     regs;
    logic [NPIN-1:0]           in_level;
    logic [NALT-1:0][NPIN-1:0] alt_out_v;
    logic [NALT-1:0][NPIN-1:0] alt_oe_v;

    assign alt_out_v = {alt_out3, alt_out2, alt_out1};
    assign alt_oe_v  = {alt_oe3, alt_oe2, alt_oe1};

    gpio_sync #(.WIDTH(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_i),
        .synced (in_level)
    );

    gpio_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .in_level (in_level),
        .rdata    (bus_rdata),
        .regs     (regs)
    );

    gpio_pin_mux u_mux (
        .regs    (regs),
        .alt_out (alt_out_v),
        .alt_oe  (alt_oe_v),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe)
    );

    // cycles since reset, saturating; used only by the synchroniser check
    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= 2'd0;
        end else if (settle_q != 2'd2) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0)); // R1

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((regs.od_en & pin_o) == '0)); // R7

    AST_SYNC_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd2) |-> (in_level == $past(pin_i, 2))); // R8
endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // write every address, then read every address back
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{8'h04, 32'h1234_5678, 32'h1234_5678},
        '{8'h08, 32'h0F1E_2D3C, 32'h0F1E_2D3C},
        '{8'h0C, 32'h4B5A_6978, 32'h4B5A_6978},
        '{8'h10, 32'h8796_A5B4, 32'h8796_A5B4},
        '{8'h14, 32'hC3D2_E1F0, 32'hC3D2_E1F0},
        '{8'h18, 32'h0000_FFFF, 32'h0000_FFFF},
        '{8'h1C, 32'hFFFF_FFFF, 32'hA5A5_0F0F},
        '{8'h20, 32'h1111_1111, 32'h1111_1111},
        '{8'h24, 32'h2222_2222, 32'h2222_2222},
        '{8'h28, 32'h3333_3333, 32'h3333_3333},
        '{8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h30, 32'h4444_4444, 32'h4444_4444},
        '{8'h34, 32'h5555_5555, 32'h5555_5555},
        '{8'h38, 32'h6666_6666, 32'h6666_6666},
        '{8'h3C, 32'h7777_7777, 32'h7777_7777},
        '{8'h40, 32'h8888_8888, 32'h8888_8888},
        '{8'h44, 32'h9999_9999, 32'h9999_9999},
        '{8'h48, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] alt_out1 = '0, alt_out2 = '0, alt_out3 = '0;
    logic [31:0] alt_oe1 = '0, alt_oe2 = '0, alt_oe3 = '0;
    logic [31:0] pin_i = 32'hA5A5_0F0F;
    logic [31:0] pin_o, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_out1(alt_out1), .alt_out2(alt_out2), .alt_out3(alt_out3),
        .alt_oe1(alt_oe1), .alt_oe2(alt_oe2), .alt_oe3(alt_oe3),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        do_reset();
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        rd(8'h00, r); chk("R1 value reg after reset", r, 32'h0);
        rd(8'h18, r); chk("R1 open-drain reg after reset", r, 32'h0);

        // R10 R8 R11: table walk
        for (int k = 0; k < NVEC; k++) wr(VEC[k].a, VEC[k].w);
        for (int k = 0; k < NVEC; k++) begin
            rd(VEC[k].a, r);
            chk($sformatf("R10/R8/R11 table entry %0d addr %h", k, VEC[k].a), r, VEC[k].e);
        end

        // R1: everything cleared by a second reset
        pin_i = 32'h0;
        do_reset();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 18; k++) begin
            rd(8'(k * 4), r);
            chk($sformatf("R1 word %0d after reset", k), r, 32'h0);
        end
        chk("R1 pins float after reset", pin_oe, 32'h0);

        // R3 R2: plain GPIO drive, pin 0 at MSB, pin 31 at LSB
        wr(8'h04, 32'h8000_0001);
        wr(8'h00, 32'h8000_0000);
        chk("R3 drive enables", pin_oe, 32'h8000_0001);
        chk("R2 pin0 high at bit31, pin31 low", pin_o & 32'h8000_0001, 32'h8000_0000);

        // R5 R4: output routing, pin0 -> src1 (low word bits 31:30), pins 16,17 -> src3 (high word)
        @(negedge clk);
        alt_out1 = 32'h8000_0000;
        alt_out3 = 32'h0000_C000;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h8000_C000);
        wr(8'h08, 32'h4000_0000);
        wr(8'h0C, 32'hF000_0000);
        chk("R5 R4 routed values", pin_o & 32'h8000_C000, 32'h8000_C000);
        @(negedge clk);
        alt_out1 = 32'h0;
        #1;
        chk("R5 pin0 follows alt_out1", pin_o & 32'h8000_0000, 32'h0);
        alt_out3 = 32'h0000_4000;
        #1;
        chk("R4 pin16 uses own high field", pin_o & 32'h0000_C000, 32'h0000_4000);

        // R6: drive routing, pin5 field 10 at bits 21:20 -> alt_oe2 bit26
        do_reset();
        alt_out1 = '0; alt_out3 = '0;
        wr(8'h10, 32'h0020_0000);
        @(negedge clk);
        alt_oe2 = 32'h0400_0000;
        #1;
        chk("R6 enable from source 2", pin_oe, 32'h0400_0000);
        alt_oe2 = 32'h0;
        alt_oe1 = 32'h0400_0000;
        #1;
        chk("R6 source 1 not selected", pin_oe, 32'h0);
        alt_oe1 = 32'h0;

        // R7: open drain on pin2 (bit29)
        do_reset();
        wr(8'h04, 32'h2000_0000);
        wr(8'h18, 32'h2000_0000);
        wr(8'h00, 32'h2000_0000);
        chk("R7 value 1 releases pin", pin_oe, 32'h0);
        chk("R7 pin_o low", pin_o, 32'h0);
        wr(8'h00, 32'h0);
        chk("R7 value 0 drives low", pin_oe, 32'h2000_0000);
        chk("R7 pin_o low when driving", pin_o, 32'h0);

        // R8: two-flop timing of the input register
        pin_i = 32'h0;
        repeat (3) @(negedge clk);
        pin_i = 32'h1234_ABCD;
        bus_addr = 8'h1C;
        @(negedge clk); chk("R8 first read after change old", bus_rdata, 32'h0);
        @(negedge clk); chk("R8 second read after change old", bus_rdata, 32'h0);
        @(negedge clk); chk("R8 third read shows new level", bus_rdata, 32'h1234_ABCD);
        wr(8'h1C, 32'h0);
        rd(8'h1C, r); chk("R8 write to input ignored", r, 32'h1234_ABCD);

        // R9: one-cycle read latency
        wr(8'h24, 32'hCAFE_0001);
        rd(8'h24, r);
        @(negedge clk);
        bus_addr = 8'h00;
        #1;
        chk("R9 rdata held before edge", bus_rdata, 32'hCAFE_0001);
        @(negedge clk);
        chk("R9 rdata updated after edge", bus_rdata, 32'h0);

        // R11: writes to reserved and unaligned leave pins untouched
        wr(8'h2D, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R11 value reg untouched", r, 32'h0);
        rd(8'h04, r); chk("R11 drive reg untouched", r, 32'h2000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule